// File: doc/BRIEF.md
# USB Host Interrupt Status Register

This block holds the interrupt status of a USB host controller. Events from the controller core arrive as one-cycle pulses or as watched values, and each one is latched into a sticky status bit. Software reads the status word and clears bits by writing ones to their positions. A second register holds one enable bit per event and a master enable. The block combines enabled status into a normal interrupt line.

Two events need extra logic. The frame-overflow bit tracks the most significant bit of the frame number, and it is judged only at the moments the frame number is posted to host memory. The root-hub change bit compares a wide watch vector, made up of the hub status word and every downstream port status word, against its value in the previous cycle. An ownership-change request goes to a separate system management interrupt line and never to the normal one. A latched unrecoverable error drives a halt output that the core uses to stop processing.

Top module: `usb_host_irq_status`

## Requirements
- R1: After reset the status word, the enable word, `irq`, `smi` and `proc_halt` are all 0.
- R2: Status bit positions are: 0 scheduling overrun, 1 done-queue writeback, 2 start of frame, 3 resume detected, 4 unrecoverable error, 5 frame-number overflow, 6 root-hub change, 30 ownership change. The enable word uses the same positions, with bit 31 as the master enable. All other bits read as 0 in both words, whatever was written to them.
- R3: A status write clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: Only hardware events set status bits, and a set bit stays set until software clears it. A write can never set a status bit.
- R5: When a hardware set and a software clear reach the same bit in the same cycle, the bit ends up set.
- R6: `irq` is 1 exactly when enable bit 31 is 1 and some status bit among 0..6 is 1 with its enable bit also 1.
- R7: Bit 5 is set in a cycle where `fn_post` is 1 and `fn_msb` differs from the `fn_msb` value seen at the previous `fn_post`. That reference is 0 after reset. A change of `fn_msb` without `fn_post` sets nothing.
- R8: Bit 6 is set in any cycle where `rh_status` or `port_status` differs from its value in the previous cycle. Both reference values are 0 after reset.
- R9: `oc_req` sets bit 30 when `HAS_SMI` is 1. `smi` is status bit 30 AND enable bit 30, independent of the master enable, and bit 30 never drives `irq`. With `HAS_SMI` at 0, bit 30 stays 0.
- R10: `proc_halt` equals status bit 4.
- R11: An event sampled at a clock edge shows in the status word right after that edge. `irq`, `smi` and `proc_halt` follow the registered words in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_sched_ovr | input | 1 | Scheduling overrun pulse |
| ev_done_wb | input | 1 | Done-queue writeback pulse |
| ev_sof | input | 1 | Start-of-frame pulse |
| ev_resume | input | 1 | Resume detected pulse |
| ev_sys_err | input | 1 | Non-USB system error pulse |
| oc_req | input | 1 | Ownership change request pulse |
| fn_msb | input | 1 | Most significant bit of the frame number |
| fn_post | input | 1 | Frame number posted to host memory this cycle |
| rh_status | input | RH_W | Root hub status word |
| port_status | input | NPORT*RH_W | Downstream port status words, concatenated |
| sts_wr | input | 1 | Status write strobe (write-one-to-clear) |
| sts_wdata | input | 32 | Status write data |
| ena_wr | input | 1 | Enable word write strobe |
| ena_wdata | input | 32 | Enable word write data |
| sts_rdata | output | 32 | Status word |
| ena_rdata | output | 32 | Enable word |
| irq | output | 1 | Normal interrupt |
| smi | output | 1 | System management interrupt |
| proc_halt | output | 1 | Unrecoverable error latched |

## Verification
The bench goes after a write-one-to-clear that lands in the same cycle as a set of the same bit. A design with clear priority would lose that event and show a 0 in bit 1. It checks that writing 0, or writing 1 to a bit that is already clear, leaves the status unchanged. A write that stored data instead of clearing would show bits that no event produced. It moves the frame number's top bit without a post strobe, then posts twice with the same top bit. An edge detector on the raw input would flag too early or twice. It also raises an ownership request with only enable bit 30 on. A design that routed it through the master enable or onto `irq` would show the wrong values on `smi` or `irq`.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned B_SO     = 0;
    localparam int unsigned B_WDH    = 1;
    localparam int unsigned B_SF     = 2;
    localparam int unsigned B_RD     = 3;
    localparam int unsigned B_UE     = 4;
    localparam int unsigned B_FNO    = 5;
    localparam int unsigned B_RHSC   = 6;
    localparam int unsigned B_OC     = 30;
    localparam int unsigned B_MASTER = 31;

    localparam logic [WORD_W-1:0] CORE_MASK = 32'h0000_007F;
    localparam logic [WORD_W-1:0] OC_MASK   = 32'h4000_0000;
    localparam logic [WORD_W-1:0] MIE_MASK  = 32'h8000_0000;

    function automatic logic [WORD_W-1:0] status_mask(input bit has_smi);
        return has_smi ? (CORE_MASK | OC_MASK) : CORE_MASK;
    endfunction
endpackage

// File: rtl/usb_irq_evt_detect.sv
module usb_irq_evt_detect #(
    parameter int unsigned WATCH_W = 96
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fn_msb,
    input  logic               fn_post,
    input  logic [WATCH_W-1:0] watch,
    output logic               fno_hit,
    output logic               rhsc_hit
);
    typedef struct packed {
        logic               fn_ref;
        logic [WATCH_W-1:0] watch_prev;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.watch_prev = watch;
        if (fn_post) begin
            st_d.fn_ref = fn_msb;
        end
        fno_hit  = fn_post && (fn_msb != st_q.fn_ref);
        rhsc_hit = (watch != st_q.watch_prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: without a post strobe the recorded top bit must not move
    p_ref_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fn_post |=> $stable(st_q.fn_ref));
    // R8: a change seen one cycle means no change is seen the next cycle if the input holds
    p_watch_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rhsc_hit ##1 (watch == $past(watch)) |-> !rhsc_hit);
endmodule

// File: rtl/usb_irq_status_bank.sv
module usb_irq_status_bank
    import usb_irq_pkg::*;
#(
    parameter bit HAS_SMI = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_vec,
    input  logic              sts_wr,
    input  logic [WORD_W-1:0] sts_wdata,
    output logic [WORD_W-1:0] sts_q
);
    localparam logic [WORD_W-1:0] IMPL = status_mask(HAS_SMI);

    typedef struct packed {
        logic [WORD_W-1:0] sts;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [WORD_W-1:0] clr_vec;

    always_comb begin
        clr_vec    = sts_wr ? sts_wdata : '0;
        bk_d.sts   = ((bk_q.sts & ~clr_vec) | set_vec) & IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign sts_q = bk_q.sts;

    // R3: a written one with no competing set leaves the bit clear
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr |=> ((sts_q & $past(sts_wdata & ~set_vec)) == '0));
    // R4: a set bit survives every cycle without a clear
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(sts_q) & ~$past(clr_vec)) & ~sts_q) == '0));
    // R4: a bit can rise only through a hardware set
    p_no_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(set_vec)) == '0));
    // R5: every implemented set lands, even against a clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((sts_q & $past(set_vec & IMPL)) == $past(set_vec & IMPL)));
endmodule

// File: rtl/usb_irq_combine.sv
module usb_irq_combine
    import usb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] sts_in,
    input  logic              ena_wr,
    input  logic [WORD_W-1:0] ena_wdata,
    output logic [WORD_W-1:0] ena_q,
    output logic              irq,
    output logic              smi
);
    localparam logic [WORD_W-1:0] ENA_MASK = CORE_MASK | OC_MASK | MIE_MASK;

    typedef struct packed {
        logic [WORD_W-1:0] ena;
    } ena_t;

    ena_t en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (ena_wr) begin
            en_d.ena = ena_wdata & ENA_MASK;
        end
        irq = en_q.ena[B_MASTER] && ((sts_in & en_q.ena & CORE_MASK) != '0);
        smi = sts_in[B_OC] && en_q.ena[B_OC];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign ena_q = en_q.ena;

    // R2: the enable word changes only on a write
    p_ena_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ena_wr |=> $stable(ena_q));
    // R9: ownership change alone never raises the normal interrupt
    p_oc_not_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_in & CORE_MASK) == '0) |-> !irq);
    // R9: management interrupt needs the latched ownership bit
    p_smi_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smi |-> sts_in[B_OC]);
endmodule

// File: rtl/usb_host_irq_status.sv
module usb_host_irq_status
    import usb_irq_pkg::*;
#(
    parameter int unsigned RH_W    = 32,
    parameter int unsigned NPORT   = 2,
    parameter bit          HAS_SMI = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ev_sched_ovr,
    input  logic                  ev_done_wb,
    input  logic                  ev_sof,
    input  logic                  ev_resume,
    input  logic                  ev_sys_err,
    input  logic                  oc_req,
    input  logic                  fn_msb,
    input  logic                  fn_post,
    input  logic [RH_W-1:0]       rh_status,
    input  logic [NPORT*RH_W-1:0] port_status,
    input  logic                  sts_wr,
    input  logic [31:0]           sts_wdata,
    input  logic                  ena_wr,
    input  logic [31:0]           ena_wdata,
    output logic [31:0]           sts_rdata,
    output logic [31:0]           ena_rdata,
    output logic                  irq,
    output logic                  smi,
    output logic                  proc_halt
);
    localparam int unsigned WATCH_W = RH_W * (NPORT + 1);

    logic              fno_hit;
    logic              rhsc_hit;
    logic              oc_set;
    logic [WORD_W-1:0] set_vec;
    logic [WORD_W-1:0] sts_q;

    usb_irq_evt_detect #(
        .WATCH_W (WATCH_W)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .fn_msb   (fn_msb),
        .fn_post  (fn_post),
        .watch    ({port_status, rh_status}),
        .fno_hit  (fno_hit),
        .rhsc_hit (rhsc_hit)
    );

    generate
        if (HAS_SMI) begin : g_oc
            assign oc_set = oc_req;
        end else begin : g_no_oc
            logic oc_unused;
            assign oc_unused = oc_req;
            assign oc_set    = 1'b0;
        end
    endgenerate

    always_comb begin
        set_vec         = '0;
        set_vec[B_SO]   = ev_sched_ovr;
        set_vec[B_WDH]  = ev_done_wb;
        set_vec[B_SF]   = ev_sof;
        set_vec[B_RD]   = ev_resume;
        set_vec[B_UE]   = ev_sys_err;
        set_vec[B_FNO]  = fno_hit;
        set_vec[B_RHSC] = rhsc_hit;
        set_vec[B_OC]   = oc_set;
    end

    usb_irq_status_bank #(
        .HAS_SMI (HAS_SMI)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .sts_wr    (sts_wr),
        .sts_wdata (sts_wdata),
        .sts_q     (sts_q)
    );

    usb_irq_combine u_combine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sts_in    (sts_q),
        .ena_wr    (ena_wr),
        .ena_wdata (ena_wdata),
        .ena_q     (ena_rdata),
        .irq       (irq),
        .smi       (smi)
    );

    assign sts_rdata = sts_q;
    assign proc_halt = sts_q[B_UE];

    // R10: an error pulse leads to halt on the next cycle
    p_err_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sys_err |=> proc_halt);
    // R7: no overflow flag rises without a post strobe the cycle before
    p_fno_needs_post_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fn_post |=> !$rose(sts_rdata[B_FNO]));
endmodule

// File: tb/usb_host_irq_status_test.sv
module usb_host_irq_status_test;
    localparam int RH_W  = 32;
    localparam int NPORT = 2;
    localparam logic [31:0] STS_MASK = 32'h4000_007F;
    localparam logic [31:0] ENA_MASK = 32'hC000_007F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_sched_ovr = 0, ev_done_wb = 0, ev_sof = 0, ev_resume = 0, ev_sys_err = 0;
    logic oc_req = 0, fn_msb = 0, fn_post = 0;
    logic [RH_W-1:0] rh_status = '0;
    logic [NPORT*RH_W-1:0] port_status = '0;
    logic sts_wr = 0, ena_wr = 0;
    logic [31:0] sts_wdata = '0, ena_wdata = '0;
    logic [31:0] sts_rdata, ena_rdata;
    logic irq, smi, proc_halt;

    int total = 0;
    int bad = 0;
    logic [31:0] e_sts = '0, e_ena = '0;
    logic e_ref = 1'b0;
    logic [RH_W*(NPORT+1)-1:0] e_prev = '0;

    always #5 clk = ~clk;

    usb_host_irq_status uut (
        .clk(clk), .rst_n(rst_n),
        .ev_sched_ovr(ev_sched_ovr), .ev_done_wb(ev_done_wb), .ev_sof(ev_sof),
        .ev_resume(ev_resume), .ev_sys_err(ev_sys_err), .oc_req(oc_req),
        .fn_msb(fn_msb), .fn_post(fn_post), .rh_status(rh_status),
        .port_status(port_status), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .ena_wr(ena_wr), .ena_wdata(ena_wdata), .sts_rdata(sts_rdata),
        .ena_rdata(ena_rdata), .irq(irq), .smi(smi), .proc_halt(proc_halt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_irq(input logic [31:0] s, input logic [31:0] e);
        return {31'd0, e[31] && ((s & e & 32'h7F) != 0)};
    endfunction

    function automatic logic [31:0] f_smi(input logic [31:0] s, input logic [31:0] e);
        return {31'd0, s[30] && e[30]};
    endfunction

    task automatic idle_inputs();
        ev_sched_ovr = 0; ev_done_wb = 0; ev_sof = 0; ev_resume = 0; ev_sys_err = 0;
        oc_req = 0; fn_post = 0; sts_wr = 0; ena_wr = 0;
        sts_wdata = '0; ena_wdata = '0;
    endtask

    // inputs are driven before the call, away from the rising edge
    task automatic tick();
        logic [31:0] setv;
        logic [RH_W*(NPORT+1)-1:0] w;
        w = {port_status, rh_status};
        setv = {1'b0, oc_req, 23'd0, (w != e_prev), (fn_post && fn_msb != e_ref),
                ev_sys_err, ev_resume, ev_sof, ev_done_wb, ev_sched_ovr};
        @(posedge clk);
        #1;
        e_sts  = ((e_sts & ~(sts_wr ? sts_wdata : 32'd0)) | setv) & STS_MASK;
        if (ena_wr) e_ena = ena_wdata & ENA_MASK;
        if (fn_post) e_ref = fn_msb;
        e_prev = w;
        chk("R11 status word", sts_rdata, e_sts);
        chk("R2 enable word", ena_rdata, e_ena);
        chk("R6 irq", {31'd0, irq}, f_irq(e_sts, e_ena));
        chk("R9 smi", {31'd0, smi}, f_smi(e_sts, e_ena));
        chk("R10 halt", {31'd0, proc_halt}, {31'd0, e_sts[4]});
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL R11 watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset status", sts_rdata, 32'd0);
        chk("R1 reset enable", ena_rdata, 32'd0);
        chk("R1 reset irq/smi/halt", {29'd0, irq, smi, proc_halt}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: writing ones to clear bits never sets them
        sts_wr = 1; sts_wdata = 32'hFFFF_FFFF; tick();
        chk("R4 write cannot set", sts_rdata, 32'd0);
        // R2: reserved enable bits read back 0
        ena_wr = 1; ena_wdata = 32'hFFFF_FFFF; tick();
        chk("R2 enable reserved zero", ena_rdata, 32'hC000_007F);
        ena_wr = 1; ena_wdata = 32'd0; tick();

        // R3: writing 0 keeps a set bit
        ev_sched_ovr = 1; tick();
        chk("R11 event visible after edge", sts_rdata, 32'h1);
        sts_wr = 1; sts_wdata = 32'd0; tick();
        chk("R3 zero write keeps", sts_rdata, 32'h1);
        sts_wr = 1; sts_wdata = 32'h1; tick();
        chk("R3 one write clears", sts_rdata, 32'h0);

        // R5: set and clear collide
        ev_done_wb = 1; tick();
        ev_done_wb = 1; sts_wr = 1; sts_wdata = 32'h2; tick();
        chk("R5 set beats clear", sts_rdata, 32'h2);
        sts_wr = 1; sts_wdata = 32'h2; tick();

        // R7: top bit moves without post, then posts
        fn_msb = 1; tick(); tick();
        chk("R7 no post no flag", sts_rdata & 32'h20, 32'h0);
        fn_post = 1; tick();
        chk("R7 post flags toggle", sts_rdata & 32'h20, 32'h20);
        sts_wr = 1; sts_wdata = 32'h20; tick();
        fn_post = 1; tick();
        chk("R7 same top bit no flag", sts_rdata & 32'h20, 32'h0);
        fn_msb = 0; fn_post = 1; tick();
        chk("R7 falling toggle flags", sts_rdata & 32'h20, 32'h20);
        sts_wr = 1; sts_wdata = 32'h20; tick();

        // R8: port word change
        port_status[40] = 1'b1; tick();
        chk("R8 port change flags", sts_rdata & 32'h40, 32'h40);
        sts_wr = 1; sts_wdata = 32'h40; tick();
        chk("R8 steady value no flag", sts_rdata & 32'h40, 32'h0);

        // R9: ownership change with only its own enable
        ena_wr = 1; ena_wdata = 32'h4000_0000; tick();
        oc_req = 1; tick();
        chk("R9 smi without master", {31'd0, smi}, 32'd1);
        chk("R9 oc not on irq", {31'd0, irq}, 32'd0);
        sts_wr = 1; sts_wdata = 32'h4000_0000; tick();

        // R6: master gating
        ena_wr = 1; ena_wdata = 32'h0000_0010; ev_sys_err = 1; tick();
        chk("R6 no master no irq", {31'd0, irq}, 32'd0);
        chk("R10 halt on error", {31'd0, proc_halt}, 32'd1);
        ena_wr = 1; ena_wdata = 32'h8000_0010; tick();
        chk("R6 master raises irq", {31'd0, irq}, 32'd1);
        sts_wr = 1; sts_wdata = 32'h10; tick();
        chk("R10 halt released", {31'd0, proc_halt}, 32'd0);

        for (int i = 0; i < 3000; i++) begin
            ev_sched_ovr = ($urandom % 8) == 0;
            ev_done_wb   = ($urandom % 8) == 0;
            ev_sof       = ($urandom % 6) == 0;
            ev_resume    = ($urandom % 16) == 0;
            ev_sys_err   = ($urandom % 32) == 0;
            oc_req       = ($urandom % 16) == 0;
            if (($urandom % 5) == 0) fn_msb = ~fn_msb;
            fn_post      = ($urandom % 4) == 0;
            if (($urandom % 16) == 0) rh_status = $urandom;
            if (($urandom % 24) == 0) port_status[($urandom % 64)] ^= 1'b1;
            sts_wr = ($urandom % 3) == 0;
            sts_wdata = $urandom;
            ena_wr = ($urandom % 10) == 0;
            ena_wdata = $urandom;
            tick();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule